// File: doc/BRIEF.md
# Flag-Setting ALU with Compare

This block is the integer execute stage of a small processor. Each cycle that `issue` is high it takes two 32-bit operands, a 3-bit opcode and a set-flags bit. On the next clock edge it registers the result, a write-enable for the destination register, and the four status flags: negative (N), zero (Z), carry (C) and overflow (V). Whether the flags are written depends on the instruction. Add and subtract write them only when the set-flags bit is high. The two compare operations always write them, and they never ask for a destination write.

A condition evaluator runs alongside the datapath. It combines the stored flags with a 4-bit condition code and drives a pass signal. Branch logic and conditional-execution logic use this signal. Because the evaluator reads the registered flags, an instruction that sets the flags affects the condition of the instructions that come after it, and never its own.

The multiplier, the barrel shifter and the register file are outside this block.

Top module: `flag_alu`

## Requirements
- R1: After reset, `result` is 0, `result_wr` is 0 and `flags_nzcv` is 0000. The flags bus is packed as N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.
- R2: An add (opcode 0) or subtract (opcode 1) issued with `set_flags` low drives `result_wr` to 1 and `result` to the sum or difference one cycle later. `flags_nzcv` is left unchanged.
- R3: An add or subtract issued with `set_flags` high also writes all four flags:
  - N is result bit 31.
  - Z is set when the result is zero.
  - C is the carry out of the add. For a subtract, C is 1 when no borrow occurs.
  - V is set on signed 32-bit overflow.
- R4: A compare (opcode 2) computes `op_a - op_b` and writes NZCV by the subtract rules, whatever `set_flags` is. On the next cycle `result_wr` is 0 and `result` keeps its previous value.
- R5: A compare-negative (opcode 3) computes `op_a + op_b` and writes NZCV by the add rules, whatever `set_flags` is. On the next cycle `result_wr` is 0 and `result` keeps its previous value.
- R6: The logic operations are AND (opcode 4), OR (opcode 5), XOR (opcode 6) and move of `op_b` (opcode 7). Each writes its result. With `set_flags` high it updates N and Z and keeps C and V. With `set_flags` low it keeps all four flags.
- R7: In a cycle with `issue` low, the next cycle has `result_wr` at 0, and both `result` and `flags_nzcv` are held.
- R8: Condition 0 (equal) passes when Z is 1. Condition 1 (not equal) passes when Z is 0.
- R9: The signed conditions compare N with V:
  - Condition 10 (GE) passes when N equals V.
  - Condition 11 (LT) is its complement.
  - Condition 12 (GT) passes when Z is 0 and N equals V.
  - Condition 13 (LE) is the complement of GT.
- R10: The single-flag and unsigned conditions:
  - Conditions 2/3 pass on C set/clear.
  - Conditions 4/5 pass on N set/clear.
  - Conditions 6/7 pass on V set/clear.
  - Condition 8 passes when C is 1 and Z is 0. Condition 9 is its complement.
- R11: Conditions 14 and 15 always pass.
- R12: `cond_pass` is combinational from `cond` and the stored flags. A flag-setting instruction changes it only after the clock edge that registers its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is present this cycle |
| opcode | input | 3 | Operation select |
| set_flags | input | 1 | Write flags for add, subtract and logic operations |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| cond | input | 4 | Condition code to evaluate |
| result | output | 32 | Registered result |
| result_wr | output | 1 | Destination write enable, registered |
| flags_nzcv | output | 4 | Stored flags, N at bit 3 down to V at bit 0 |
| cond_pass | output | 1 | Condition passes on the stored flags |

## Verification
A wrong carry or overflow term is visible on `flags_nzcv` in the cycle right after the instruction. It also changes `cond_pass` for the unsigned and signed conditions from then on, so the bench checks every condition against each flag state it creates. A flag register that is written when it should not be shows up one cycle after an add without the set-flags bit, a logic operation or an idle cycle. A destination write wrongly enabled for a compare shows up at once as `result_wr` high, or as `result` changing.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_CMN = 3'd3,
        OP_AND = 3'd4,
        OP_ORR = 3'd5,
        OP_EOR = 3'd6,
        OP_MOV = 3'd7
    } op_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam int COND_W = 4;

    localparam logic [COND_W-1:0] CC_EQ = 4'd0;
    localparam logic [COND_W-1:0] CC_NE = 4'd1;
    localparam logic [COND_W-1:0] CC_CS = 4'd2;
    localparam logic [COND_W-1:0] CC_CC = 4'd3;
    localparam logic [COND_W-1:0] CC_MI = 4'd4;
    localparam logic [COND_W-1:0] CC_PL = 4'd5;
    localparam logic [COND_W-1:0] CC_VS = 4'd6;
    localparam logic [COND_W-1:0] CC_VC = 4'd7;
    localparam logic [COND_W-1:0] CC_HI = 4'd8;
    localparam logic [COND_W-1:0] CC_LS = 4'd9;
    localparam logic [COND_W-1:0] CC_GE = 4'd10;
    localparam logic [COND_W-1:0] CC_LT = 4'd11;
    localparam logic [COND_W-1:0] CC_GT = 4'd12;
    localparam logic [COND_W-1:0] CC_LE = 4'd13;

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_t               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output nzcv_t             fl
);
    localparam int MSB = DATA_W - 1;

    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;
    logic              ovf;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_CMP);
        b_eff  = is_sub ? ~b : b;
        sum    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
        ovf    = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        unique case (op)
            OP_AND:  y = a & b;
            OP_ORR:  y = a | b;
            OP_EOR:  y = a ^ b;
            OP_MOV:  y = b;
            default: y = sum[MSB:0];
        endcase
        fl.n = y[MSB];
        fl.z = (y == '0);
        fl.c = sum[DATA_W];
        fl.v = ovf;
    end
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_pkg::*;
(
    input  nzcv_t             fl,
    input  logic [COND_W-1:0] cc,
    output logic              pass
);
    logic sgn_ge;

    always_comb begin
        sgn_ge = (fl.n == fl.v);
        unique case (cc)
            CC_EQ:   pass = fl.z;
            CC_NE:   pass = !fl.z;
            CC_CS:   pass = fl.c;
            CC_CC:   pass = !fl.c;
            CC_MI:   pass = fl.n;
            CC_PL:   pass = !fl.n;
            CC_VS:   pass = fl.v;
            CC_VC:   pass = !fl.v;
            CC_HI:   pass = fl.c && !fl.z;
            CC_LS:   pass = !fl.c || fl.z;
            CC_GE:   pass = sgn_ge;
            CC_LT:   pass = !sgn_ge;
            CC_GT:   pass = !fl.z && sgn_ge;
            CC_LE:   pass = fl.z || !sgn_ge;
            default: pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [2:0]        opcode,
    input  logic              set_flags,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        cond,
    output logic [DATA_W-1:0] result,
    output logic              result_wr,
    output logic [3:0]        flags_nzcv,
    output logic              cond_pass
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        nzcv_t             fl;
    } state_t;

    state_t            st_d, st_q;
    op_t               op;
    logic [DATA_W-1:0] core_y;
    nzcv_t             core_fl;
    logic              is_arith, is_cmp;

    assign op = op_t'(opcode);

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op (op),
        .a  (op_a),
        .b  (op_b),
        .y  (core_y),
        .fl (core_fl)
    );

    alu_cond_eval u_cond (
        .fl   (st_q.fl),
        .cc   (cond),
        .pass (cond_pass)
    );

    always_comb begin
        st_d     = st_q;
        st_d.wr  = 1'b0;
        is_cmp   = (op == OP_CMP) || (op == OP_CMN);
        is_arith = (op == OP_ADD) || (op == OP_SUB);
        if (issue) begin
            if (!is_cmp) begin
                st_d.res = core_y;
                st_d.wr  = 1'b1;
            end
            if (is_cmp || (is_arith && set_flags)) begin
                st_d.fl = core_fl;
            end else if (set_flags) begin
                st_d.fl.n = core_fl.n;
                st_d.fl.z = core_fl.z;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result     = st_q.res;
    assign result_wr  = st_q.wr;
    assign flags_nzcv = st_q.fl;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [2:0]        opcode,
    input logic              set_flags,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [3:0]        cond,
    input logic [DATA_W-1:0] result,
    input logic              result_wr,
    input logic [3:0]        flags_nzcv,
    input logic              cond_pass
);
    // R2
    arith_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !set_flags && (opcode == 3'd0 || opcode == 3'd1))
        |=> (result_wr && $stable(flags_nzcv)));

    // R4
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (opcode == 3'd2 || opcode == 3'd3))
        |=> (!result_wr && $stable(result)));

    // R6
    logic_cv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode[2])
        |=> (result_wr && $stable(flags_nzcv[1:0])));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!result_wr && $stable(result) && $stable(flags_nzcv)));

    // R8
    eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd0) |-> (cond_pass == flags_nzcv[2]));

    // R11
    always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond[3:1] == 3'b111) |-> cond_pass);

    // R3
    arith_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && set_flags && (opcode == 3'd0 || opcode == 3'd1))
        |=> (flags_nzcv[2] == (result == '0)) && (flags_nzcv[3] == result[DATA_W-1]));
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .opcode     (opcode),
    .set_flags  (set_flags),
    .op_a       (op_a),
    .op_b       (op_b),
    .cond       (cond),
    .result     (result),
    .result_wr  (result_wr),
    .flags_nzcv (flags_nzcv),
    .cond_pass  (cond_pass)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [2:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  cond = '0;
    logic [31:0] result;
    logic        result_wr;
    logic [3:0]  flags_nzcv;
    logic        cond_pass;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [31:0] exp_res = '0;
    logic        exp_wr = 1'b0;
    logic [3:0]  exp_fl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .set_flags(set_flags), .op_a(op_a), .op_b(op_b), .cond(cond),
        .result(result), .result_wr(result_wr), .flags_nzcv(flags_nzcv),
        .cond_pass(cond_pass)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES && !done) begin
            failures++;
            $display("FAIL watchdog act=%0d exp<=%0d", cycles, MAX_CYCLES);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic cond_model(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !(cy && !z);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return !(!z && (n == v));
            default: return 1'b1;
        endcase
    endfunction

    // Bench model of one issued instruction, from the requirements.
    task automatic model(input logic [2:0] op, input logic s, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w;
        logic [31:0] r;
        logic cy, v;
        cy = 1'b0; v = 1'b0;
        case (op)
            3'd0, 3'd3: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[31:0]; cy = w[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'd1, 3'd2: begin
                w = {1'b0, a} + {1'b0, ~b} + 33'd1;
                r = w[31:0]; cy = w[32];
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            3'd4: r = a & b;
            3'd5: r = a | b;
            3'd6: r = a ^ b;
            default: r = b;
        endcase
        exp_wr = !(op == 3'd2 || op == 3'd3);
        if (exp_wr) exp_res = r;
        if (op == 3'd2 || op == 3'd3 || (s && op <= 3'd1))
            exp_fl = {r[31], r == 32'd0, cy, v};
        else if (s)
            exp_fl = {r[31], r == 32'd0, exp_fl[1:0]};
    endtask

    task automatic run_op(input string tag, input logic [2:0] op, input logic s,
                          input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        issue = 1'b1; opcode = op; set_flags = s; op_a = a; op_b = b;
        model(op, s, a, b);
        @(negedge clk);
        issue = 1'b0;
        chk({tag, " wr"}, {31'd0, result_wr}, {31'd0, exp_wr});
        chk({tag, " result"}, result, exp_res);
        chk({tag, " flags"}, {28'd0, flags_nzcv}, {28'd0, exp_fl});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_res = '0; exp_wr = 1'b0; exp_fl = '0;
        chk("R1 result", result, 32'd0);
        chk("R1 wr", {31'd0, result_wr}, 32'd0);
        chk("R1 flags", {28'd0, flags_nzcv}, 32'd0);
    endtask

    task automatic t_cond_sweep(input string tag);
        for (int c = 0; c < 16; c++) begin
            cond = c[3:0];
            #1;
            chk($sformatf("%s cond=%0d R8 R9 R10 R11", tag, c), {31'd0, cond_pass},
                {31'd0, cond_model(c[3:0], exp_fl)});
        end
    endtask

    task automatic t_noflags;
        run_op("R3 setup sub", 3'd1, 1'b1, 32'd3, 32'd5);
        run_op("R2 add noS", 3'd0, 1'b0, 32'h7FFF_FFFF, 32'd1);
        run_op("R2 sub noS", 3'd1, 1'b0, 32'd9, 32'd9);
    endtask

    task automatic t_flags;
        run_op("R3 add ovf", 3'd0, 1'b1, 32'h7FFF_FFFF, 32'd1);
        t_cond_sweep("R9 nv");
        run_op("R3 add carry zero", 3'd0, 1'b1, 32'hFFFF_FFFF, 32'd1);
        t_cond_sweep("R10 cz");
        run_op("R3 sub equal", 3'd1, 1'b1, 32'd5, 32'd5);
        run_op("R3 sub borrow", 3'd1, 1'b1, 32'd3, 32'd5);
        t_cond_sweep("R9 lt");
        run_op("R3 sub signed ovf", 3'd1, 1'b1, 32'h8000_0000, 32'd1);
    endtask

    task automatic t_compare;
        run_op("R2 base", 3'd0, 1'b0, 32'h1234, 32'h1);
        run_op("R4 cmp gt", 3'd2, 1'b0, 32'd10, 32'd4);
        t_cond_sweep("R9 gt");
        run_op("R4 cmp ovf", 3'd2, 1'b1, 32'h8000_0000, 32'd1);
        run_op("R5 cmn zero", 3'd3, 1'b0, 32'hFFFF_FFFF, 32'd1);
        t_cond_sweep("R8 eq");
        run_op("R5 cmn neg", 3'd3, 1'b1, 32'h8000_0000, 32'h8000_0000);
    endtask

    task automatic t_logic;
        run_op("R3 setup carry", 3'd0, 1'b1, 32'hFFFF_FFFF, 32'd2);
        run_op("R6 and S", 3'd4, 1'b1, 32'hF0F0_0000, 32'h0F0F_0000);
        run_op("R6 orr S", 3'd5, 1'b1, 32'h8000_0000, 32'h1);
        run_op("R6 eor noS", 3'd6, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF);
        run_op("R6 mov S", 3'd7, 1'b1, 32'h5555_AAAA, 32'h0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        opcode = 3'd0; op_a = 32'hDEAD; op_b = 32'h1; set_flags = 1'b1; issue = 1'b0;
        exp_wr = 1'b0;
        @(negedge clk);
        chk("R7 idle wr", {31'd0, result_wr}, 32'd0);
        chk("R7 idle result", result, exp_res);
        chk("R7 idle flags", {28'd0, flags_nzcv}, {28'd0, exp_fl});
    endtask

    task automatic t_cond_timing;
        run_op("R3 clear z", 3'd1, 1'b1, 32'd2, 32'd1);
        cond = 4'd0;
        @(negedge clk);
        issue = 1'b1; opcode = 3'd1; set_flags = 1'b1; op_a = 32'd7; op_b = 32'd7;
        #1;
        chk("R12 before edge", {31'd0, cond_pass}, 32'd0);
        model(3'd1, 1'b1, 32'd7, 32'd7);
        @(negedge clk);
        issue = 1'b0;
        chk("R12 after edge", {31'd0, cond_pass}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_cond_sweep("R11 reset");
        t_noflags();
        t_flags();
        t_compare();
        t_logic();
        t_idle();
        t_cond_timing();
        t_cond_sweep("R10 final");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule